// File: doc/BRIEF.md
# Line Alarm Indication Persistence Detector

This block inspects the automatic protection switching byte carried in each received frame's line overhead and decides whether an upstream line alarm indication is present. A three-bit field inside that byte is compared against an all-ones pattern every time an upstream extractor presents the byte together with a valid strobe. The defect is set only after an unbroken run of matching frames, and it is removed only after an unbroken run of non-matching frames. Because both directions need a run, a single noisy byte cannot toggle the alarm.

The detector drives a level that is high while the defect stands. It also drives two single-cycle event pulses, one when the defect is raised and one when it is dropped, which downstream event logic can latch. The run length is a parameter with a default of five frames. The position of the inspected field is also a parameter.

Top module: `lais_detector`

## Requirements
- R1: After synchronous reset, `defect_o` is 0, and `raise_o` and `drop_o` are 0.
- R2: A byte matches when its three least significant bits, `k2_i[2:0]`, are all 1. These are the sixth, seventh and eighth bits when bits are counted 1 to 8 from the most significant. Bits 7..3 have no effect on matching.
- R3: While clear, `defect_o` rises in the cycle after the RUN_LEN-th (default 5) consecutive valid matching byte.
- R4: While declared, `defect_o` falls in the cycle after the RUN_LEN-th consecutive valid non-matching byte.
- R5: A valid byte that breaks a run restarts the count. A clear block therefore stays clear after four matches followed by one non-match, and a declared block stays declared after four non-matches followed by one match.
- R6: Cycles where `k2_vld_i` is low change neither the count nor the state. A run may be spread across gaps.
- R7: `raise_o` is high for exactly one cycle, in the same cycle that `defect_o` first reads 1. At no other time is it high.
- R8: `drop_o` is high for exactly one cycle, in the same cycle that `defect_o` first reads 0 after being 1. At no other time is it high.
- R9: After each state change the count restarts from zero for the opposite condition. Valid bytes that continue the same condition after a change have no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| k2_vld_i | input | 1 | K2 byte valid strobe, one per frame |
| k2_i | input | 8 | Received K2 byte |
| defect_o | output | 1 | Line AIS defect declared |
| raise_o | output | 1 | One-cycle pulse on declaration |
| drop_o | output | 1 | One-cycle pulse on clearance |

## Verification
A wrong run counter shows up as a `defect_o` edge that comes one or more valid frames too early or too late. It can also show up as an edge after a run that was broken, and this appears in the cycle after the offending strobe. A wrong state register shows up in the same way. It also shows up as an event pulse with no matching level edge, and the pulses are compared against the level in every cycle. Random strobe gaps and random bytes near the pattern exercise the counter in both directions, with and without gaps.

// File: rtl/lais_pkg.sv
package lais_pkg;
   typedef enum logic {ST_CLEAR = 1'b0, ST_DECL = 1'b1} lais_state_e;
endpackage

// File: rtl/lais_match.sv
module lais_match #(
   parameter int BYTE_W  = 8,
   parameter int FIELD_W = 3,
   parameter int FIELD_LSB = 0
) (
   input  logic [BYTE_W-1:0] byte_i,
   output logic              hit_o
);
   initial begin
      if (FIELD_LSB + FIELD_W > BYTE_W)
         $error("lais_match: field exceeds byte");
   end
   localparam logic [FIELD_W-1:0] PATTERN = '1;
   assign hit_o = (byte_i[FIELD_LSB +: FIELD_W] == PATTERN);
endmodule

// File: rtl/lais_run_cnt.sv
module lais_run_cnt #(
   parameter int RUN_LEN = 5,
   localparam int CNT_W = $clog2(RUN_LEN + 1)
) (
   input  logic clk,
   input  logic rst,
   input  logic step_i,
   input  logic qual_i,
   output logic done_o
);
   initial begin
      if (RUN_LEN < 1) $error("lais_run_cnt: RUN_LEN must be >= 1");
   end
   localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (step_i) begin
         if (!qual_i || cnt_q == LAST) cnt_q <= '0;
         else cnt_q <= cnt_q + 1'b1;
      end
   end

   assign done_o = step_i && qual_i && (cnt_q == LAST);

   a_r6_hold_no_step: assert property (@(posedge clk) disable iff (rst)
      !step_i |=> $stable(cnt_q));
   a_r5_break_restart: assert property (@(posedge clk) disable iff (rst)
      (step_i && !qual_i) |=> (cnt_q == '0));
   a_r9_bounded: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LAST);
endmodule

// File: rtl/lais_detector.sv
module lais_detector
   import lais_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int FIELD_W   = 3,
   parameter int FIELD_LSB = 0,
   parameter int RUN_LEN   = 5
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              k2_vld_i,
   input  logic [BYTE_W-1:0] k2_i,
   output logic              defect_o,
   output logic              raise_o,
   output logic              drop_o
);
   lais_state_e st_q;
   logic hit, qual, done;

   lais_match #(.BYTE_W(BYTE_W), .FIELD_W(FIELD_W), .FIELD_LSB(FIELD_LSB)) u_match (
      .byte_i(k2_i), .hit_o(hit));

   // qualifying condition is the one that would move the state
   assign qual = (st_q == ST_CLEAR) ? hit : !hit;

   lais_run_cnt #(.RUN_LEN(RUN_LEN)) u_cnt (
      .clk(clk), .rst(rst), .step_i(k2_vld_i), .qual_i(qual), .done_o(done));

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q    <= ST_CLEAR;
         raise_o <= 1'b0;
         drop_o  <= 1'b0;
      end else begin
         raise_o <= done && (st_q == ST_CLEAR);
         drop_o  <= done && (st_q == ST_DECL);
         if (done) st_q <= (st_q == ST_CLEAR) ? ST_DECL : ST_CLEAR;
      end
   end

   assign defect_o = (st_q == ST_DECL);

   a_r7_raise_edge: assert property (@(posedge clk) disable iff (rst)
      raise_o |-> (defect_o && !$past(defect_o)));
   a_r8_drop_edge: assert property (@(posedge clk) disable iff (rst)
      drop_o |-> (!defect_o && $past(defect_o)));
   a_r7_rise_has_pulse: assert property (@(posedge clk) disable iff (rst)
      $rose(defect_o) |-> raise_o);
   a_r8_fall_has_pulse: assert property (@(posedge clk) disable iff (rst)
      $fell(defect_o) |-> drop_o);
   a_r6_no_strobe_stable: assert property (@(posedge clk) disable iff (rst)
      !k2_vld_i |=> $stable(defect_o));
   a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
      $onehot0({raise_o, drop_o}));
endmodule

// File: tb/lais_detector_test.sv
module lais_detector_test;
   localparam int RUN = 5;
   logic clk = 0, rst = 1, vld = 0;
   logic [7:0] k2 = 0;
   logic defect, raise, drop;
   int checks = 0, fails = 0;
   // bench model
   bit m_def = 0;
   int m_cnt = 0;
   bit m_raise = 0, m_drop = 0;

   lais_detector uut (.clk(clk), .rst(rst), .k2_vld_i(vld), .k2_i(k2),
      .defect_o(defect), .raise_o(raise), .drop_o(drop));

   always #10 clk = ~clk;

   function automatic bit is_hit(logic [7:0] b);
      return b[2:0] == 3'b111;
   endfunction

   task automatic chk(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0b expected %0b", req, act, exp);
      end
   endtask

   task automatic model_step(bit v, logic [7:0] b);
      m_raise = 0; m_drop = 0;
      if (v) begin
         if (is_hit(b) != m_def) begin
            m_cnt++;
            if (m_cnt == RUN) begin
               m_cnt = 0; m_def = !m_def;
               m_raise = m_def; m_drop = !m_def;
            end
         end else m_cnt = 0;
      end
   endtask

   // one cycle: drive at negedge, compare after the next posedge
   task automatic cyc(bit v, logic [7:0] b, string req);
      @(negedge clk);
      vld = v; k2 = b;
      model_step(v, b);
      @(posedge clk); #2;
      chk(req, defect, m_def);
      chk("R7", raise, m_raise);
      chk("R8", drop, m_drop);
   endtask

   initial begin
      #3000000;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk("R1", defect, 0); chk("R1", raise, 0); chk("R1", drop, 0);
      @(negedge clk); rst = 0;
      // R3: five matches, upper bits varied (R2)
      for (int i = 0; i < 5; i++) cyc(1, 8'h07 | 8'(i << 4), "R3");
      chk("R3", defect, 1);
      // R9: more matches do nothing
      for (int i = 0; i < 7; i++) cyc(1, 8'hFF, "R9");
      // R5: four non-matches then a match, stays declared
      for (int i = 0; i < 4; i++) cyc(1, 8'h06, "R5");
      cyc(1, 8'h07, "R5");
      chk("R5", defect, 1);
      // R4 with gaps (R6)
      for (int i = 0; i < 5; i++) begin
         cyc(0, 8'h00, "R6");
         cyc(1, 8'h03, "R4");
      end
      chk("R4", defect, 0);
      // R2: near-miss patterns never declare
      for (int i = 0; i < 10; i++) cyc(1, 8'hF8 | 8'(i % 7), "R2");
      chk("R2", defect, 0);
      // R5: four matches then a break, stays clear
      for (int i = 0; i < 4; i++) cyc(1, 8'h07, "R5");
      cyc(1, 8'h05, "R5");
      for (int i = 0; i < 4; i++) cyc(1, 8'h07, "R5");
      chk("R5", defect, 0);
      cyc(1, 8'h07, "R3");
      chk("R3", defect, 1);
      // random: biased to long runs
      void'($urandom(32'd1234));
      for (int i = 0; i < 4000; i++) begin
         logic [7:0] b = 8'($urandom);
         bit v = ($urandom % 4) != 0;
         if (($urandom % 8) < 5) b = m_def ? (b | 8'h07) : b;
         if (($urandom % 3) == 0) b[2:0] = 3'b111;
         cyc(v, b, "R6");
      end
      @(negedge clk); vld = 0;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule